// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running calendar time, given as BCD bytes for seconds, minutes, hours and day of month, and compares it with four programmable alarm fields. Each alarm field carries a wildcard bit in bit 7. When that bit is set, the field matches any time value. The comparison is made only on the cycle where a one-cycle seconds strobe is high, so a match can raise the pending flag at most once per second. If all four wildcard bits are set, the block produces one event every second.

Software programs the fields over a simple byte-wide register port. A status register reports the pending flag and clears it when read. A control register holds the interrupt enable. The interrupt output is active high. It stays high for as long as the flag and the enable are both set.

Top module: `bcd_alarm_cmp`

## Requirements
- R1: After reset, all four alarm fields, the status register (0xE) and the control register (0xF) read 0x00, and `irq` is low.
- R2: The alarm fields sit at offsets 0x8 (seconds), 0x9 (minutes), 0xA (hours) and 0xB (day of month). Bit 7 of each field is the wildcard and is stored as written. Seconds and minutes keep value bits 6:0. Hours and day keep value bits 5:0 and read bit 6 as 0.
- R3: When the seconds strobe is high and every field matches, status bit 0 is set at the next clock edge. A field without its wildcard matches when its stored value bits equal the same bits of the time input.
- R4: A field with its wildcard set matches any time value. With all four wildcards set, every seconds strobe sets the flag.
- R5: The flag is not set without a strobe, even when the time matches. It is also not set on a strobe when any field without its wildcard differs.
- R6: A read of 0xE returns the flag in bit 0 as it stood before the access, with bits 7:1 zero. The flag is clear after that edge.
- R7: `irq` is high exactly while the flag is set and enable bit 3 of 0xF is set. The flag sets even when the enable is clear. All other bits of 0xF read 0.
- R8: A strobe with a match in the same cycle as a read of 0xE leaves the flag set. That read still returns the old value.
- R9: Writes to 0xE and to unmapped offsets have no effect. Reads of unmapped offsets return 0x00.
- R10: Time input bits above a field's value width do not affect the match: bit 7 for seconds and minutes, bits 7:6 for hours and day.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_tick | input | 1 | One-cycle strobe once per second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_mday | input | 8 | Current day of month, BCD |
| bus_addr | input | AW | Register offset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; a read of 0xE clears the flag |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the current state |
| irq | output | 1 | Interrupt, active high |

## Verification
A matching seconds strobe and a read of the status register can fall in the same cycle. In that case setting the flag and clearing it compete for the same edge. The bench provokes this by raising the strobe and the status read together, both with the flag clear and with it already set. It judges the result by the value the read returns in that cycle, which must be the old flag. It then reads again to confirm that the flag survived and that `irq` still follows it.

// File: rtl/bcd_alarm_cmp.sv
module bcd_alarm_cmp #(
  parameter int AW = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sec_tick,
  input  logic [7:0]    cur_sec,
  input  logic [7:0]    cur_min,
  input  logic [7:0]    cur_hour,
  input  logic [7:0]    cur_mday,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr,
  input  logic          bus_rd,
  input  logic [7:0]    bus_wdata,
  output logic [7:0]    bus_rdata,
  output logic          irq
);
  localparam int NFLD = 4;
  localparam logic [AW-1:0] OFS_ALM  = AW'(8);
  localparam logic [AW-1:0] OFS_STAT = AW'(14);
  localparam logic [AW-1:0] OFS_CTRL = AW'(15);
  localparam int IE_BIT = 3;

  logic [NFLD-1:0][7:0] alm;
  logic [NFLD-1:0][7:0] now;
  logic [NFLD-1:0]      fld_hit;
  logic                 hit;
  logic                 flag;
  logic                 ie;
  logic                 rd_stat;

  assign now     = {cur_mday, cur_hour, cur_min, cur_sec};
  assign hit     = &fld_hit;
  assign rd_stat = bus_rd && (bus_addr == OFS_STAT);

  wire unused_hi = &{cur_sec[7], cur_min[7], cur_hour[7:6], cur_mday[7:6]};

  for (genvar i = 0; i < NFLD; i++) begin : g_fld
    localparam logic [6:0] VMASK = (i < 2) ? 7'h7F : 7'h3F;
    logic [7:0] q;
    always_ff @(posedge clk) begin
      if (!rst_n) q <= '0;
      else if (bus_wr && bus_addr == OFS_ALM + AW'(i))
        q <= {bus_wdata[7], bus_wdata[6:0] & VMASK};
    end
    assign alm[i]     = q;
    assign fld_hit[i] = q[7] | ((now[i][6:0] & VMASK) == q[6:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                flag <= 1'b0;
    else if (sec_tick && hit)  flag <= 1'b1;
    else if (rd_stat)          flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) ie <= 1'b0;
    else if (bus_wr && bus_addr == OFS_CTRL) ie <= bus_wdata[IE_BIT];
  end

  always_comb begin
    bus_rdata = 8'h00;
    case (bus_addr)
      OFS_ALM:           bus_rdata = alm[0];
      OFS_ALM + AW'(1):  bus_rdata = alm[1];
      OFS_ALM + AW'(2):  bus_rdata = alm[2];
      OFS_ALM + AW'(3):  bus_rdata = alm[3];
      OFS_STAT:          bus_rdata = {7'b0, flag};
      OFS_CTRL:          bus_rdata = 8'(ie) << IE_BIT;
      default:           bus_rdata = 8'h00;
    endcase
  end

  assign irq = flag & ie;

  assert_match_sets_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && hit) |=> (bus_rdata[0] || bus_addr != OFS_STAT) && flag);

  assert_all_wild_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && alm[0][7] && alm[1][7] && alm[2][7] && alm[3][7]) |=> flag);

  assert_no_tick_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sec_tick && !rd_stat) |=> $stable(flag));

  assert_read_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && !(sec_tick && hit)) |=> !irq);

  assert_set_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stat && sec_tick && hit) |=> irq == ie);
endmodule

// File: tb/tb_bcd_alarm_cmp.sv
module tb_bcd_alarm_cmp;
  localparam int AW = 5;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sec_tick = 1'b0;
  logic [7:0] cur_sec = 0, cur_min = 0, cur_hour = 0, cur_mday = 0;
  logic [AW-1:0] bus_addr = 0;
  logic bus_wr = 0, bus_rd = 0;
  logic [7:0] bus_wdata = 0;
  logic [7:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  bcd_alarm_cmp #(.AW(AW)) dut (.*);

  // {alarm sec,min,hour,mday, time sec,min,hour,mday, expected flag}
  localparam logic [64:0] VEC [8] = '{
    {8'h30,8'h15,8'h12,8'h25, 8'h30,8'h15,8'h12,8'h25, 1'b1},
    {8'h30,8'h15,8'h12,8'h25, 8'h31,8'h15,8'h12,8'h25, 1'b0},
    {8'h30,8'h15,8'h92,8'h25, 8'h30,8'h15,8'h07,8'h25, 1'b1},
    {8'h80,8'h80,8'h80,8'h80, 8'h59,8'h42,8'h23,8'h31, 1'b1},
    {8'h00,8'h00,8'h00,8'h01, 8'h00,8'h00,8'h00,8'h02, 1'b0},
    {8'h10,8'h20,8'h12,8'h05, 8'h10,8'h20,8'h52,8'hC5, 1'b1},
    {8'h80,8'h44,8'h80,8'h80, 8'h12,8'h45,8'h01,8'h01, 1'b0},
    {8'h30,8'h80,8'h80,8'h80, 8'hB0,8'h00,8'h00,8'h01, 1'b1}
  };

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); sec_tick = 1'b1;
    @(negedge clk); sec_tick = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual hung expected done");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    for (int a = 8; a < 12; a++) begin rd(AW'(a), d); chk("R1 alarm", d, 8'h00); end
    rd(AW'(14), d); chk("R1 status", d, 8'h00);
    rd(AW'(15), d); chk("R1 control", d, 8'h00);
    chk("R1 irq", {7'b0, irq}, 8'h00);

    // R2 field widths and wildcard storage
    wr(AW'(8), 8'hFF);  rd(AW'(8), d);  chk("R2 sec", d, 8'hFF);
    wr(AW'(9), 8'h7F);  rd(AW'(9), d);  chk("R2 min", d, 8'h7F);
    wr(AW'(10), 8'hFF); rd(AW'(10), d); chk("R2 hour", d, 8'hBF);
    wr(AW'(11), 8'h7F); rd(AW'(11), d); chk("R2 mday", d, 8'h3F);
    // R7 control: only enable bit kept
    wr(AW'(15), 8'hFF); rd(AW'(15), d); chk("R7 ctrl read", d, 8'h08);

    // table walk, enable on: R3 R4 R5 R10
    for (int v = 0; v < 8; v++) begin
      wr(AW'(8),  VEC[v][64:57]);
      wr(AW'(9),  VEC[v][56:49]);
      wr(AW'(10), VEC[v][48:41]);
      wr(AW'(11), VEC[v][40:33]);
      cur_sec = VEC[v][32:25]; cur_min = VEC[v][24:17];
      cur_hour = VEC[v][16:9]; cur_mday = VEC[v][8:1];
      tick();
      chk($sformatf("R3 irq vec%0d", v), {7'b0, irq}, {7'b0, VEC[v][0]});
      rd(AW'(14), d);
      chk($sformatf("R3 status vec%0d", v), d, {7'b0, VEC[v][0]});
    end

    // R5 match without strobe
    wr(AW'(8), 8'h80); wr(AW'(9), 8'h80); wr(AW'(10), 8'h80); wr(AW'(11), 8'h80);
    repeat (5) @(negedge clk);
    rd(AW'(14), d); chk("R5 no strobe", d, 8'h00);

    // R7 flag sets with enable off, irq stays low
    wr(AW'(15), 8'h00);
    tick();
    chk("R7 irq gated", {7'b0, irq}, 8'h00);
    rd(AW'(14), d); chk("R7 flag without enable", d, 8'h01);
    // R6 read clears and irq drops
    wr(AW'(15), 8'h08);
    tick();
    chk("R7 irq high", {7'b0, irq}, 8'h01);
    rd(AW'(14), d); chk("R6 read old value", d, 8'h01);
    chk("R6 irq after clear", {7'b0, irq}, 8'h00);
    rd(AW'(14), d); chk("R6 cleared", d, 8'h00);

    // R8 strobe and status read in the same cycle, flag clear before
    @(negedge clk); sec_tick = 1'b1; bus_rd = 1'b1; bus_addr = AW'(14);
    #1 d = bus_rdata; chk("R8 read old clear", d, 8'h00);
    @(negedge clk); sec_tick = 1'b0; bus_rd = 1'b0;
    chk("R8 irq set", {7'b0, irq}, 8'h01);
    // same with flag already set
    @(negedge clk); sec_tick = 1'b1; bus_rd = 1'b1; bus_addr = AW'(14);
    #1 d = bus_rdata; chk("R8 read old set", d, 8'h01);
    @(negedge clk); sec_tick = 1'b0; bus_rd = 1'b0;
    rd(AW'(14), d); chk("R8 flag survived", d, 8'h01);

    // R9 ignored writes and unmapped offsets
    wr(AW'(14), 8'h01); rd(AW'(14), d); chk("R9 status write", d, 8'h00);
    wr(AW'(3), 8'h5A);  rd(AW'(3), d);  chk("R9 unmapped read", d, 8'h00);
    rd(AW'(8), d); chk("R9 alarm untouched", d, 8'h80);

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule